// File: doc/BRIEF.md
# Interrupt Pacing Controller

This block holds the interrupt cause register and interrupt mask of a network controller and decides when its interrupt line may rise. Event sources pulse cause bits. The controller merges each pulse into the cause register and then judges whether the line may be raised now. A programmable pacing interval enforces a minimum spacing between two assertions of the line. This spacing is counted from the previous assertion, not from when the newest cause arrived. A request that comes too early leaves one deferred post waiting. That post goes out as soon as the spacing has elapsed.

When a post does raise the line, the block also does two things. It stops any receive or transmit delay timer that is still pending, using one-cycle cancel strobes. It records each stopped group in a summary cause bit. A posting attempt finds nothing to raise when the unmasked part of the cause register is empty. Clearing causes or changing the mask can leave that part empty. In that case the line drops and any waiting deferred post is discarded.

The pacing unit is 256 ns. The parameter `CLK_NS` turns it into clock cycles, rounding up. A statistics counter counts every posting attempt that reaches the mask check.

Top module: `irq_pace_ctrl`

## Requirements
- R1: A bit set in `cause_evt` is ORed into `cause` at the next clock edge and stays set until cleared. Several bits may arrive together. If a bit is set in `cause_evt` and in `cause_clr` in the same cycle, the set wins.
- R2: Each bit set in `cause_clr` clears the matching `cause` bit at the next clock edge. Other bits are left unchanged.
- R3: A request is any non-zero `cause_evt`. It posts in the same cycle, and `irq` reads 1 after that edge, when `pace_ivl` is 0, when `force_now` is 1, or when at least `pace_ivl*ceil(256/CLK_NS)` cycles have passed since the edge of the last assertion.
- R4: A request that cannot post at once arms a single deferred post. That post fires at edge E+W, where E is the edge of the last assertion and W is the window in cycles. Further requests made while it is armed do not move it.
- R5: A posting attempt leaves `irq` unchanged when no cause bit, other than the top bit, is set in both the cause register and the mask. `mask_wdata` bit i enables cause bit i.
- R6: A posting attempt that raises `irq` pulses `rx_tmr_cancel` and `tx_tmr_cancel` for one cycle. Each pulse equals the pending inputs sampled in that cycle. If any receive timer was pending, cause bit 1 is set. If any transmit timer was pending, cause bit 0 is set. A masked attempt pulses nothing.
- R7: Each assertion sets the top cause bit (bit CAUSE_W-1) together with `irq`. It also restarts the pacing window from that edge.
- R8: After a mask write or a cause clear, if no unmasked cause is left, `irq` and the top cause bit clear at the next edge and any armed deferred post is discarded.
- R9: `post_count` rises by one for every posting attempt, whether immediate or a deferred post that fires, and whether masked or not. A deferral alone does not count.
- R10: After reset, `irq`, `cause`, the mask, both cancel outputs and `post_count` are 0. The first request after reset may post at once whatever `pace_ivl` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cause_evt | input | CAUSE_W | Cause pulses. A non-zero value is a posting request |
| force_now | input | 1 | Bypass the pacing window for this request |
| cause_clr | input | CAUSE_W | Write-one-to-clear strobes for cause bits |
| mask_we | input | 1 | Load the mask from `mask_wdata` |
| mask_wdata | input | CAUSE_W | New mask value. A 1 enables that cause |
| pace_ivl | input | ITV_W | Pacing interval in units of 256 ns |
| rx_tmr_pend | input | N_TMR | Receive delay timers currently pending |
| tx_tmr_pend | input | N_TMR | Transmit delay timers currently pending |
| irq | output | 1 | Interrupt line |
| cause | output | CAUSE_W | Cause register |
| rx_tmr_cancel | output | N_TMR | One-cycle cancel strobes to the receive timers |
| tx_tmr_cancel | output | N_TMR | One-cycle cancel strobes to the transmit timers |
| post_count | output | STAT_W | Number of posting attempts |

## Verification
A corrupted window counter or deferred-post flag shows up as the edge at which `irq` rises. The bench therefore measures that edge against the last assertion, for every request offset across several intervals. An error of a single cycle is caught on the first affected request. A deferred flag that fails to clear after a mask drop shows up as a spurious `irq` one window later. A wrong mask or cause fold shows up in `cause`, `irq` or the cancel strobes one edge after the stimulus.

// File: rtl/irq_pace_pkg.sv
// Package irq_pace_pkg
// Shared constants, the posting-action encoding and the conversion from the
// 256 ns pacing unit to clock cycles for the interrupt pacing controller.
// Assumes the clock period is given in whole nanoseconds.
package irq_pace_pkg;

    // Summary cause bit set when a transmit delay timer is cancelled.
    localparam int unsigned TX_DONE_BIT = 0;
    // Summary cause bit set when a receive delay timer is cancelled.
    localparam int unsigned RX_TMR_BIT  = 1;
    // Length of one pacing unit in nanoseconds.
    localparam int unsigned PACE_UNIT_NS = 256;

    // What the controller does with the current cycle.
    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,   // nothing to post
        ACT_NOW   = 2'd1,   // post a new request immediately
        ACT_DEFER = 2'd2,   // request must wait; keep one deferred post
        ACT_FIRE  = 2'd3    // the deferred post is due
    } post_act_e;

    // Clock cycles per pacing unit, rounded up so the spacing is never short.
    function automatic int unsigned unit_cycles(input int unsigned clk_ns);
        return (PACE_UNIT_NS + clk_ns - 1) / clk_ns;
    endfunction

endpackage

// File: rtl/irq_pace_age.sv
// Module irq_pace_age
// Counts clock edges since the last interrupt assertion and reports whether
// the pacing window has elapsed. The counter saturates at the largest window,
// so it cannot wrap, and it resets saturated so the first post is not held.
// Assumes restart pulses for exactly the edge of an assertion.
module irq_pace_age #(
    parameter int unsigned ITV_W    = 16,
    parameter int unsigned UNIT_CYC = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [ITV_W-1:0] pace_ivl,
    output logic             win_open
);

    localparam int unsigned AGE_MAX = ((1 << ITV_W) - 1) * UNIT_CYC;
    localparam int unsigned AGE_W   = $clog2(AGE_MAX + 1);
    localparam logic [AGE_W-1:0] AGE_TOP = AGE_W'(AGE_MAX);
    localparam logic [AGE_W-1:0] AGE_ONE = AGE_W'(1);

    logic [AGE_W-1:0] age_q;
    logic [AGE_W-1:0] window;

    // Window length in cycles for the current interval setting.
    assign window = AGE_W'(pace_ivl) * AGE_W'(UNIT_CYC);

    // Edge counter since the last assertion, saturating at the largest window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= AGE_TOP;
        end else if (restart) begin
            age_q <= AGE_ONE;
        end else if (age_q != AGE_TOP) begin
            age_q <= age_q + AGE_ONE;
        end
    end

    // Open once the last assertion plus the window is at or before this edge.
    assign win_open = (age_q >= window);

    AST_AGE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != '0) && (age_q <= AGE_TOP)); // R7

endmodule

// File: rtl/irq_pace_cause.sv
// Module irq_pace_cause
// Holds the cause register and the interrupt mask. It offers a look-ahead
// flag saying whether any unmasked cause, other than the asserted bit, will
// be set once this cycle's pulses, clears and mask write are applied.
// Assumes set_asrt and drop_asrt are never high together.
module irq_pace_cause
    import irq_pace_pkg::*;
#(
    parameter int unsigned CAUSE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] evt,
    input  logic [CAUSE_W-1:0] clr,
    input  logic               mask_we,
    input  logic [CAUSE_W-1:0] mask_wdata,
    input  logic               set_rx,
    input  logic               set_tx,
    input  logic               set_asrt,
    input  logic               drop_asrt,
    output logic [CAUSE_W-1:0] cause_q,
    output logic               live
);

    localparam logic [CAUSE_W-1:0] ASRT_BIT_M = {1'b1, {(CAUSE_W-1){1'b0}}};
    localparam logic [CAUSE_W-1:0] RX_BIT_M   = CAUSE_W'(1) << RX_TMR_BIT;
    localparam logic [CAUSE_W-1:0] TX_BIT_M   = CAUSE_W'(1) << TX_DONE_BIT;

    logic [CAUSE_W-1:0] mask_q;
    logic [CAUSE_W-1:0] mask_nx;
    logic [CAUSE_W-1:0] cause_base;
    logic [CAUSE_W-1:0] cause_nx;

    // Apply clears first so a simultaneous pulse on the same bit survives.
    assign cause_base = (cause_q & ~clr) | evt;
    assign mask_nx    = mask_we ? mask_wdata : mask_q;

    // Look-ahead: an unmasked cause remains after this cycle's updates.
    assign live = |(cause_base & mask_nx & ~ASRT_BIT_M);

    // Fold the summary bits and the asserted bit into the next cause value.
    always_comb begin
        cause_nx = cause_base;
        if (set_rx) begin
            cause_nx = cause_nx | RX_BIT_M;
        end
        if (set_tx) begin
            cause_nx = cause_nx | TX_BIT_M;
        end
        if (set_asrt) begin
            cause_nx = cause_nx | ASRT_BIT_M;
        end else if (drop_asrt) begin
            cause_nx = cause_nx & ~ASRT_BIT_M;
        end
    end

    // Cause and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            mask_q  <= '0;
        end else begin
            cause_q <= cause_nx;
            mask_q  <= mask_nx;
        end
    end

    AST_EVT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((cause_q & $past(evt & ~ASRT_BIT_M)) == $past(evt & ~ASRT_BIT_M))); // R1

    AST_NO_DOUBLE_ASRT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_asrt && drop_asrt)); // R8

endmodule

// File: rtl/irq_pace_stat.sv
// Module irq_pace_stat
// Counts posting attempts. A parameter selects whether the counter stops at
// its top value or wraps to zero. Assumes bump is high for one cycle per attempt.
module irq_pace_stat #(
    parameter int unsigned STAT_W   = 16,
    parameter bit          SATURATE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bump,
    output logic [STAT_W-1:0] count
);

    localparam logic [STAT_W-1:0] CNT_ONE = STAT_W'(1);

    logic [STAT_W-1:0] cnt_q;
    logic              at_top;

    // Pick the overflow behaviour at elaboration time.
    generate
        if (SATURATE) begin : g_sat
            assign at_top = &cnt_q;
        end else begin : g_wrap
            assign at_top = 1'b0;
        end
    endgenerate

    // Attempt counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (bump && !at_top) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    assign count = cnt_q;

    AST_STAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (count == $past(count)) || (count == $past(count) + CNT_ONE)); // R9

endmodule

// File: rtl/irq_pace_ctrl.sv
// Module irq_pace_ctrl (top)
// Interrupt pacing controller. Each cycle it decides whether a request posts
// now, arms the single deferred post, or whether that deferred post is due.
// It drives the interrupt line, the timer cancel strobes and the summary
// cause bits. Assumes the delay-timer pending flags are stable for the cycle
// they are sampled and that the timers act on a one-cycle cancel pulse.
module irq_pace_ctrl
    import irq_pace_pkg::*;
#(
    parameter int unsigned CAUSE_W = 8,
    parameter int unsigned ITV_W   = 16,
    parameter int unsigned CLK_NS  = 20,
    parameter int unsigned STAT_W  = 16,
    parameter int unsigned N_TMR   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] cause_evt,
    input  logic               force_now,
    input  logic [CAUSE_W-1:0] cause_clr,
    input  logic               mask_we,
    input  logic [CAUSE_W-1:0] mask_wdata,
    input  logic [ITV_W-1:0]   pace_ivl,
    input  logic [N_TMR-1:0]   rx_tmr_pend,
    input  logic [N_TMR-1:0]   tx_tmr_pend,
    output logic               irq,
    output logic [CAUSE_W-1:0] cause,
    output logic [N_TMR-1:0]   rx_tmr_cancel,
    output logic [N_TMR-1:0]   tx_tmr_cancel,
    output logic [STAT_W-1:0]  post_count
);

    localparam int unsigned UNIT_CYC = unit_cycles(CLK_NS);
    localparam int unsigned ASRT_IDX = CAUSE_W - 1;

    post_act_e        act;
    logic             req;
    logic             win_open;
    logic             live;
    logic             attempt;
    logic             hit;
    logic             recheck;
    logic             drop;
    logic             armed_q;
    logic             irq_q;
    logic [N_TMR-1:0] rx_cancel_q;
    logic [N_TMR-1:0] tx_cancel_q;

    assign req = |cause_evt;

    // Decide this cycle's posting action; a due deferred post goes first.
    always_comb begin
        if (armed_q && win_open) begin
            act = ACT_FIRE;
        end else if (req && (pace_ivl == '0 || force_now || win_open)) begin
            act = ACT_NOW;
        end else if (req) begin
            act = ACT_DEFER;
        end else begin
            act = ACT_IDLE;
        end
    end

    // An attempt reaches the mask check; a hit actually raises the line.
    assign attempt = (act == ACT_NOW) || (act == ACT_FIRE);
    assign hit     = attempt && live;

    // A mask write or clear that leaves nothing unmasked withdraws the line.
    assign recheck = mask_we || (|cause_clr);
    assign drop    = recheck && !live;

    // Window tracker restarted by every assertion.
    irq_pace_age #(
        .ITV_W    (ITV_W),
        .UNIT_CYC (UNIT_CYC)
    ) u_age (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (hit),
        .pace_ivl (pace_ivl),
        .win_open (win_open)
    );

    // Cause and mask storage with summary-bit folding.
    irq_pace_cause #(
        .CAUSE_W (CAUSE_W)
    ) u_cause (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (cause_evt),
        .clr        (cause_clr),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .set_rx     (hit && (|rx_tmr_pend)),
        .set_tx     (hit && (|tx_tmr_pend)),
        .set_asrt   (hit),
        .drop_asrt  (drop),
        .cause_q    (cause),
        .live       (live)
    );

    // Attempt statistics.
    irq_pace_stat #(
        .STAT_W   (STAT_W),
        .SATURATE (1'b1)
    ) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (attempt),
        .count (post_count)
    );

    // Single deferred post: armed by a held request, consumed by any attempt or drop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (attempt || drop) begin
            armed_q <= 1'b0;
        end else if (act == ACT_DEFER) begin
            armed_q <= 1'b1;
        end
    end

    // Interrupt line: raised by a hit, lowered by a drop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (hit) begin
            irq_q <= 1'b1;
        end else if (drop) begin
            irq_q <= 1'b0;
        end
    end

    // One-cycle cancel strobes to every pending delay timer at assertion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_cancel_q <= '0;
            tx_cancel_q <= '0;
        end else begin
            rx_cancel_q <= hit ? rx_tmr_pend : '0;
            tx_cancel_q <= hit ? tx_tmr_pend : '0;
        end
    end

    assign irq           = irq_q;
    assign rx_tmr_cancel = rx_cancel_q;
    assign tx_tmr_cancel = tx_cancel_q;

    AST_RISE_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(force_now || (pace_ivl == '0) || win_open)); // R3

    AST_IRQ_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cause[ASRT_IDX]); // R7

    AST_RX_CANCEL_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (|rx_tmr_cancel) |-> (cause[RX_TMR_BIT] && irq)); // R6

    AST_TX_CANCEL_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (|tx_tmr_cancel) |-> (cause[TX_DONE_BIT] && irq)); // R6

    AST_DEFER_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !win_open && !force_now && (pace_ivl != '0)) |=> !$rose(irq)); // R4

endmodule

// File: tb/irq_pace_ctrl_test.sv
// Bench for irq_pace_ctrl. It sweeps request offsets against the pacing
// window for small intervals and predicts the rise edge arithmetically.
// Directed cases cover masking, cancel strobes, clears and the counter.
module irq_pace_ctrl_test;

    localparam int CW   = 8;
    localparam int IW   = 4;
    localparam int CNS  = 20;
    localparam int UNIT = (256 + CNS - 1) / CNS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cause_evt = '0;
    logic          force_now = 1'b0;
    logic [CW-1:0] cause_clr = '0;
    logic          mask_we = 1'b0;
    logic [CW-1:0] mask_wdata = '0;
    logic [IW-1:0] pace_ivl = '0;
    logic [1:0]    rx_tmr_pend = '0;
    logic [1:0]    tx_tmr_pend = '0;
    logic          irq;
    logic [CW-1:0] cause;
    logic [1:0]    rx_tmr_cancel;
    logic [1:0]    tx_tmr_cancel;
    logic [15:0]   post_count;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int exp_cnt = 0;

    irq_pace_ctrl #(
        .CAUSE_W (CW), .ITV_W (IW), .CLK_NS (CNS), .STAT_W (16), .N_TMR (2)
    ) uut (
        .clk (clk), .rst_n (rst_n), .cause_evt (cause_evt), .force_now (force_now),
        .cause_clr (cause_clr), .mask_we (mask_we), .mask_wdata (mask_wdata),
        .pace_ivl (pace_ivl), .rx_tmr_pend (rx_tmr_pend), .tx_tmr_pend (tx_tmr_pend),
        .irq (irq), .cause (cause), .rx_tmr_cancel (rx_tmr_cancel),
        .tx_tmr_cancel (tx_tmr_cancel), .post_count (post_count)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (edge %0d)", tag, act, exp, cyc);
        end
    endtask

    // Drive a request for one edge; r_edge is the edge that samples it.
    task automatic pulse(input logic [CW-1:0] ev, input logic frc, output int r_edge);
        cause_evt = ev;
        force_now = frc;
        r_edge = cyc + 1;
        @(negedge clk);
        cause_evt = '0;
        force_now = 1'b0;
    endtask

    task automatic clear_bits(input logic [CW-1:0] bits);
        cause_clr = bits;
        @(negedge clk);
        cause_clr = '0;
    endtask

    task automatic write_mask(input logic [CW-1:0] m);
        mask_we = 1'b1;
        mask_wdata = m;
        @(negedge clk);
        mask_we = 1'b0;
    endtask

    // Report the edge after which irq first reads 1, or -1 within the limit.
    task automatic wait_rise(input int limit, output int e);
        e = -1;
        for (int k = 0; k < limit; k++) begin
            if (irq) begin
                e = cyc;
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        #(20 * 200000);
        chk(1'b0, "watchdog", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        int r0, e0, r1, e1, w, expf, seen;

        // R10: reset state.
        repeat (3) @(negedge clk);
        chk(irq == 1'b0, "R10 irq", irq, 0);
        chk(cause == '0, "R10 cause", cause, 0);
        chk(post_count == '0, "R10 count", post_count, 0);
        chk(rx_tmr_cancel == '0 && tx_tmr_cancel == '0, "R10 cancel",
            {rx_tmr_cancel, tx_tmr_cancel}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Enable every cause but bit 4 and the asserted bit.
        write_mask(8'h6F);
        chk(irq == 1'b0, "R5 mask only", irq, 0);

        // R10: first request posts at once even with the largest interval.
        pace_ivl = '1;
        pulse(8'h04, 1'b0, r0);
        exp_cnt++;
        wait_rise(2, e0);
        chk(e0 == r0, "R10 first post", e0, r0);
        chk(cause == 8'h84, "R7 asserted bit", cause, 8'h84);

        // R1: a forced second request ORs in its bit.
        pulse(8'h08, 1'b1, r1);
        exp_cnt++;
        chk(cause == 8'h8C, "R1 or-in", cause, 8'h8C);

        // R2: clear one bit; another unmasked bit keeps the line up.
        clear_bits(8'h04);
        chk(cause == 8'h88, "R2 clear one", cause, 8'h88);
        chk(irq == 1'b1, "R2 line held", irq, 1);

        // R8: clearing everything drops the line and the asserted bit.
        clear_bits('1);
        chk(irq == 1'b0 && cause == '0, "R8 clear drop", {irq, cause}, 0);

        // R5: masked attempt latches the cause, does not raise the line, still counts.
        pace_ivl = '0;
        pulse(8'h10, 1'b0, r0);
        exp_cnt++;
        chk(irq == 1'b0, "R5 masked irq", irq, 0);
        chk(cause == 8'h10, "R5 masked cause", cause, 8'h10);
        chk(post_count == 16'(exp_cnt), "R9 masked counted", post_count, exp_cnt);

        // R6: assertion cancels pending timers and folds the summary bits.
        clear_bits('1);
        rx_tmr_pend = 2'b10;
        tx_tmr_pend = 2'b01;
        pulse(8'h20, 1'b0, r0);
        exp_cnt++;
        rx_tmr_pend = 2'b00;
        tx_tmr_pend = 2'b00;
        chk(rx_tmr_cancel == 2'b10, "R6 rx cancel", rx_tmr_cancel, 2);
        chk(tx_tmr_cancel == 2'b01, "R6 tx cancel", tx_tmr_cancel, 1);
        chk(cause == 8'hA3, "R6 fold bits", cause, 8'hA3);
        @(negedge clk);
        chk(rx_tmr_cancel == '0 && tx_tmr_cancel == '0, "R6 one cycle",
            {rx_tmr_cancel, tx_tmr_cancel}, 0);

        // R6: a masked attempt cancels nothing.
        clear_bits('1);
        rx_tmr_pend = 2'b11;
        pulse(8'h10, 1'b0, r0);
        exp_cnt++;
        rx_tmr_pend = 2'b00;
        chk(rx_tmr_cancel == '0, "R6 masked no cancel", rx_tmr_cancel, 0);
        chk(cause == 8'h10, "R6 masked no fold", cause, 8'h10);

        // R8: a mask drop discards the armed deferred post.
        clear_bits('1);
        pace_ivl = 4'd3;
        pulse(8'h04, 1'b1, r0);
        exp_cnt++;
        clear_bits(8'h04);
        pulse(8'h08, 1'b0, r1);
        write_mask(8'h00);
        write_mask(8'h6F);
        seen = 0;
        for (int k = 0; k < 3 * UNIT + 20; k++) begin
            if (irq) seen = 1;
            @(negedge clk);
        end
        chk(seen == 0, "R8 deferred discarded", seen, 0);
        chk(post_count == 16'(exp_cnt), "R9 no fire counted", post_count, exp_cnt);

        // R3 / R4: sweep the request offset against the window for each interval.
        for (int iv = 0; iv < 4; iv++) begin
            pace_ivl = IW'(iv);
            w = iv * UNIT;
            for (int d = 0; d <= w + 2; d++) begin
                clear_bits('1);
                pulse(8'h04, 1'b1, r0);
                exp_cnt++;
                wait_rise(3, e0);
                chk(e0 == r0, "R3 forced post", e0, r0);
                clear_bits(8'h04);
                chk(irq == 1'b0, "R8 drop in sweep", irq, 0);
                repeat (d) @(negedge clk);
                pulse(8'h08, 1'b0, r1);
                exp_cnt++;
                expf = (r1 > e0 + w) ? r1 : e0 + w;
                wait_rise(w + 6, e1);
                chk(e1 == expf, (expf == r1) ? "R3 immediate edge" : "R4 deferred edge",
                    e1, expf);
            end
        end

        // R9: total attempts.
        chk(post_count == 16'(exp_cnt), "R9 total count", post_count, exp_cnt);

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule